// File: doc/BRIEF.md
# Vectored Interrupt Controller with Rotating Priority

This block gathers up to 64 interrupt request lines and presents them to a processor through a small word-addressed register window. Every source owns one control byte that enables it, picks its trigger type (active-high level, rising edge, falling edge or both edges), and routes it to one of eight destinations. The destinations are a normal interrupt line, a fast interrupt line and six auxiliary lines.

Edge-triggered sources are held in a latch until software clears them by writing a one to their status bit. Level-triggered sources show their input directly. For the normal and the fast line, a vector register reports the number of the winning pending source. The winner is the lowest-numbered one, or, with rotation switched on, the first one found after the source most recently acknowledged.

Top module: `intc_vector_ctrl`

## Requirements
- R1: After reset every control byte is zero, all eight destination outputs are low, and both vector registers (IRQ at byte offset 0x20, FIQ at 0x24) read 0x0000003F.
- R2: The control byte of source i sits at byte offset 0x40+i. It is byte lane i mod 4 of the word at 0x40+4*(i div 4) and is written only when that lane's strobe is set. Bits [2:0] hold the destination, bit 3 the enable, bit 5 rising-edge mode and bit 6 falling-edge mode. Bits 4 and 7 always read zero.
- R3: When bits 5 and 6 are both zero, the source's status bit equals its input in the same cycle, and writing a one to that bit has no effect.
- R4: In edge mode a selected transition of the input sets the status bit at the clock edge that follows the change. The bit stays set after the input returns. Sources 0..31 appear in the word at 0x80 and sources 32..63 in the word at 0x84, at bit i mod 32.
- R5: Writing a one to the status bit of an edge-mode source clears the latch. Writing a zero leaves it set.
- R6: With enable (bit 3) clear, a source drives no output and never wins a vector register, but its status bit still reports it.
- R7: A destination output is high exactly while some enabled pending source is routed to it. Code 0 is IRQ, 1 is FIQ, and codes 2..7 are aux_o[0]..aux_o[5].
- R8: Under fixed priority, bits [5:0] of a vector register give the lowest-numbered enabled pending source routed to that output.
- R9: With nothing pending for an output its vector reads 63. A real source 63 is told apart by bit 31 of the word at 0x84.
- R10: Bit 6 of a vector register turns on rotation for that output. An acknowledge is a write that sets the status bit of the source the register currently reports. After an acknowledge, the search starts one past that source and wraps modulo 64.
- R11: Bit 6 reads back as written. Clearing it returns the output to fixed priority without further writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_i | input | 64 | Raw interrupt request lines |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| aux_o | output | 6 | Auxiliary destination lines |

## Verification
The hardest state to reach from the ports is a rotation pointer that has to wrap past the top of the source range. The pointer moves only when software acknowledges the exact source the vector register currently reports. The stimulus therefore holds three level sources pending at once, spread across both status words, and turns on rotation. It then acknowledges each reported winner in turn, reading the vector after every write, until the search has gone past source 63 and comes back to the lowest source. Clearing the rotation bit at that point shows the fixed order again.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned CTRL_BITS  = 8;
   localparam int unsigned BIT_EN     = 3;
   localparam int unsigned BIT_RISE   = 5;
   localparam int unsigned BIT_FALL   = 6;
   localparam logic [7:0]  CTRL_WMASK = 8'h6F;
   localparam int unsigned DEST_W     = 3;
   localparam int unsigned NUM_DEST   = 8;
   localparam int unsigned ROT_BIT    = 6;
   localparam int unsigned VEC_FIELD  = 6;

   localparam int unsigned OFF_VEC_IRQ = 32'h20;
   localparam int unsigned OFF_VEC_FIQ = 32'h24;
   localparam int unsigned OFF_CTRL    = 32'h40;
   localparam int unsigned OFF_STAT    = 32'h80;

   typedef enum logic [DEST_W-1:0] {
      DST_IRQ  = 3'd0,
      DST_FIQ  = 3'd1,
      DST_AUX0 = 3'd2,
      DST_AUX1 = 3'd3,
      DST_AUX2 = 3'd4,
      DST_AUX3 = 3'd5,
      DST_AUX4 = 3'd6,
      DST_AUX5 = 3'd7
   } dest_e;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
   import intc_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 src_i,
   input  logic                 ctrl_we,
   input  logic [CTRL_BITS-1:0] ctrl_wdata,
   input  logic                 ack_i,
   output logic [CTRL_BITS-1:0] ctrl_q,
   output logic                 pend_o,
   output logic                 lvl_o
);
   logic prev_q;
   logic latch_q;
   logic edge_mode;
   logic hit;

   assign edge_mode = ctrl_q[BIT_RISE] | ctrl_q[BIT_FALL];
   assign hit = (ctrl_q[BIT_RISE] & src_i & ~prev_q) |
                (ctrl_q[BIT_FALL] & ~src_i & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q <= src_i;
         if (ctrl_we)
            ctrl_q <= ctrl_wdata & CTRL_WMASK;
         if (!edge_mode)
            latch_q <= 1'b0;
         else if (hit)
            latch_q <= 1'b1;
         else if (ack_i)
            latch_q <= 1'b0;
      end
   end

   assign pend_o = edge_mode ? latch_q : src_i;
   assign lvl_o  = ~edge_mode;
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
   parameter int unsigned N   = 64,
   parameter int unsigned IDW = $clog2(N)
) (
   input  logic [N-1:0]   cand,
   input  logic [IDW-1:0] start,
   output logic           valid,
   output logic [IDW-1:0] vec
);
   logic [N-1:0] rot;

   assign rot   = N'({cand, cand} >> start);
   assign valid = |cand;

   always_comb begin
      vec = IDW'(N - 1);
      for (int i = N - 1; i >= 0; i--) begin
         if (rot[i])
            vec = start + IDW'(i);
      end
   end
endmodule

// File: rtl/intc_vector_ctrl.sv
module intc_vector_ctrl
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC        = 64,
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned DATA_W         = 32,
   parameter bit          ROTATE_SUPPORT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W/8-1:0]   bus_be,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_SRC-1:0]    src_i,
   output logic                  irq_o,
   output logic                  fiq_o,
   output logic [NUM_DEST-3:0]   aux_o
);
   localparam int unsigned IDW        = $clog2(NUM_SRC);
   localparam int unsigned BPW        = DATA_W / 8;
   localparam int unsigned CTRL_WORDS = NUM_SRC / BPW;
   localparam int unsigned STAT_WORDS = NUM_SRC / DATA_W;
   localparam int unsigned WA_W       = ADDR_W - 2;
   localparam logic [WA_W-1:0] WA_VEC_IRQ  = WA_W'(OFF_VEC_IRQ >> 2);
   localparam logic [WA_W-1:0] WA_VEC_FIQ  = WA_W'(OFF_VEC_FIQ >> 2);
   localparam logic [WA_W-1:0] WA_CTRL     = WA_W'(OFF_CTRL >> 2);
   localparam logic [WA_W-1:0] WA_CTRL_END = WA_W'((OFF_CTRL >> 2) + CTRL_WORDS);
   localparam logic [WA_W-1:0] WA_STAT     = WA_W'(OFF_STAT >> 2);
   localparam logic [WA_W-1:0] WA_STAT_END = WA_W'((OFF_STAT >> 2) + STAT_WORDS);

   if (DATA_W != 32) begin : g_bad_data
      $error("intc_vector_ctrl: DATA_W must be 32");
   end
   if (NUM_SRC != 32 && NUM_SRC != 64) begin : g_bad_src
      $error("intc_vector_ctrl: NUM_SRC must be 32 or 64");
   end
   if (ADDR_W != 8) begin : g_bad_addr
      $error("intc_vector_ctrl: ADDR_W must be 8");
   end

   // ---------------- address decode ----------------
   logic [WA_W-1:0] wa;
   logic            aligned;
   logic            ctrl_hit;
   logic            stat_hit;
   logic [WA_W-1:0] ctrl_idx;
   logic [WA_W-1:0] stat_idx;

   assign wa       = bus_addr[ADDR_W-1:2];
   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign ctrl_hit = aligned && (wa >= WA_CTRL) && (wa < WA_CTRL_END);
   assign stat_hit = aligned && (wa >= WA_STAT) && (wa < WA_STAT_END);
   assign ctrl_idx = wa - WA_CTRL;
   assign stat_idx = wa - WA_STAT;

   // ---------------- per-source cells ----------------
   logic [NUM_SRC*CTRL_BITS-1:0] ctrl_all;
   logic [NUM_SRC-1:0]           src_pend;
   logic [NUM_SRC-1:0]           lvl_mask;
   logic [NUM_SRC-1:0]           src_en;
   logic [NUM_SRC-1:0]           w1c_vec;
   logic [DEST_W-1:0]            src_dest [NUM_SRC];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic                 cell_we;
      logic [CTRL_BITS-1:0] cell_ctrl;

      assign cell_we = bus_we && ctrl_hit && (ctrl_idx == WA_W'(i / BPW)) &&
                       bus_be[i % BPW];
      assign w1c_vec[i] = bus_we && stat_hit && (stat_idx == WA_W'(i / DATA_W)) &&
                          bus_be[(i % DATA_W) / 8] && bus_wdata[i % DATA_W];

      intc_src_cell u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .src_i      (src_i[i]),
         .ctrl_we    (cell_we),
         .ctrl_wdata (bus_wdata[(i % BPW)*8 +: 8]),
         .ack_i      (w1c_vec[i]),
         .ctrl_q     (cell_ctrl),
         .pend_o     (src_pend[i]),
         .lvl_o      (lvl_mask[i])
      );

      assign ctrl_all[i*CTRL_BITS +: CTRL_BITS] = cell_ctrl;
      assign src_en[i]   = cell_ctrl[BIT_EN];
      assign src_dest[i] = cell_ctrl[DEST_W-1:0];
   end

   // ---------------- routing ----------------
   logic [NUM_SRC-1:0]  active;
   logic [NUM_SRC-1:0]  dest_vec [NUM_DEST];
   logic [NUM_DEST-1:0] dest_act;

   assign active = src_pend & src_en;

   always_comb begin
      for (int d = 0; d < NUM_DEST; d++) begin
         for (int i = 0; i < NUM_SRC; i++)
            dest_vec[d][i] = (src_dest[i] == DEST_W'(d));
         dest_act[d] = |(active & dest_vec[d]);
      end
   end

   assign irq_o = dest_act[DST_IRQ];
   assign fiq_o = dest_act[DST_FIQ];
   assign aux_o = dest_act[NUM_DEST-1:2];

   // ---------------- vector pickers ----------------
   logic [NUM_SRC-1:0] pick_cand  [2];
   logic [IDW-1:0]     pick_start [2];
   logic [IDW-1:0]     pick_vec   [2];
   logic [1:0]         pick_val;
   logic [1:0]         rot_en;

   for (genvar k = 0; k < 2; k++) begin : g_out
      assign pick_cand[k] = active & dest_vec[k];

      intc_prio_pick #(.N(NUM_SRC), .IDW(IDW)) u_pick (
         .cand  (pick_cand[k]),
         .start (pick_start[k]),
         .valid (pick_val[k]),
         .vec   (pick_vec[k])
      );

      if (ROTATE_SUPPORT) begin : g_rot
         logic           rot_q;
         logic [IDW-1:0] last_q;
         logic           rot_we;
         logic           ack_win;

         assign rot_we  = bus_we && aligned && bus_be[0] &&
                          (wa == ((k == 0) ? WA_VEC_IRQ : WA_VEC_FIQ));
         assign ack_win = pick_val[k] && w1c_vec[pick_vec[k]];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rot_q  <= 1'b0;
               last_q <= IDW'(NUM_SRC - 1);
            end else begin
               if (rot_we)
                  rot_q <= bus_wdata[ROT_BIT];
               if (ack_win)
                  last_q <= pick_vec[k];
            end
         end

         assign rot_en[k]     = rot_q;
         assign pick_start[k] = rot_q ? last_q + IDW'(1) : '0;
      end else begin : g_fixed
         assign rot_en[k]     = 1'b0;
         assign pick_start[k] = '0;
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (aligned && (wa == WA_VEC_IRQ || wa == WA_VEC_FIQ)) begin
         bus_rdata[IDW-1:0] = (wa == WA_VEC_IRQ) ? pick_vec[0] : pick_vec[1];
         bus_rdata[ROT_BIT] = (wa == WA_VEC_IRQ) ? rot_en[0] : rot_en[1];
      end else if (ctrl_hit) begin
         for (int w = 0; w < CTRL_WORDS; w++)
            if (ctrl_idx == WA_W'(w))
               bus_rdata = ctrl_all[w*DATA_W +: DATA_W];
      end else if (stat_hit) begin
         for (int w = 0; w < STAT_WORDS; w++)
            if (stat_idx == WA_W'(w))
               bus_rdata = src_pend[w*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/intc_vector_chk.sv
module intc_vector_chk #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned IDW     = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic               irq_o,
   input logic               fiq_o,
   input logic [5:0]         aux_o,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] lvl_mask,
   input logic [NUM_SRC-1:0] cand_irq,
   input logic [NUM_SRC-1:0] cand_fiq,
   input logic               val_irq,
   input logic               val_fiq,
   input logic [IDW-1:0]     vec_irq,
   input logic [IDW-1:0]     vec_fiq
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!irq_o && !fiq_o && aux_o == '0));

   assert_level_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend ^ src_i) & lvl_mask) == '0);

   assert_irq_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == val_irq);

   assert_fiq_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o == val_fiq);

   assert_irq_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      val_irq |-> cand_irq[vec_irq]);

   assert_fiq_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      val_fiq |-> cand_fiq[vec_fiq]);

   assert_idle_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !val_irq |-> vec_irq == IDW'(NUM_SRC - 1));
endmodule

bind intc_vector_ctrl intc_vector_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_i    (src_i),
   .irq_o    (irq_o),
   .fiq_o    (fiq_o),
   .aux_o    (aux_o),
   .pend     (src_pend),
   .lvl_mask (lvl_mask),
   .cand_irq (pick_cand[0]),
   .cand_fiq (pick_cand[1]),
   .val_irq  (pick_val[0]),
   .val_fiq  (pick_val[1]),
   .vec_irq  (pick_vec[0]),
   .vec_fiq  (pick_vec[1])
);

// File: tb/intc_vector_ctrl_tb.sv
`timescale 1ns/1ps
module intc_vector_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] src_i = '0;
   logic        irq_o, fiq_o;
   logic [5:0]  aux_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   intc_vector_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o), .aux_o(aux_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; src_i = '0; bus_we = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0; bus_be = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic set_src(input int idx, input logic v);
      @(posedge clk); #1;
      src_i[idx] = v;
   endtask

   // control byte of source i placed in its lane
   task automatic wr_ctrl(input int idx, input logic [7:0] v);
      wr(8'(8'h40 + 4*(idx/4)), 32'(v) << (8*(idx%4)), 4'(1 << (idx%4)));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      rd(8'h20, d); check("R1 irq vector", d, 32'h3F);
      rd(8'h24, d); check("R1 fiq vector", d, 32'h3F);
      rd(8'h7C, d); check("R1 ctrl word", d, 32'h0);
      check("R1 outputs", {24'b0, aux_o, fiq_o, irq_o}, 32'h0);
   endtask

   task automatic t_ctrl_rw();
      logic [31:0] d;
      do_reset();
      wr(8'h44, 32'hFF5A3C29, 4'b1010);
      rd(8'h44, d); check("R2 lane strobes and masked bits", d, 32'h6F002C00);
      wr(8'h44, 32'h00000009, 4'b0001);
      rd(8'h44, d); check("R2 lane 0 write", d, 32'h6F002C09);
   endtask

   task automatic t_level();
      logic [31:0] d;
      do_reset();
      set_src(9, 1'b1);
      rd(8'h80, d); check("R3 level follows input", d, 32'h200);
      wr(8'h80, 32'h200, 4'hF);
      rd(8'h80, d); check("R3 level ignores W1", d, 32'h200);
      set_src(9, 1'b0);
      rd(8'h80, d); check("R3 level drops with input", d, 32'h0);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      do_reset();
      wr_ctrl(5, 8'h28);
      wr_ctrl(33, 8'h48);
      set_src(33, 1'b1);
      set_src(5, 1'b1);
      rd(8'h80, d); check("R4 not latched before edge", d, 32'h0);
      @(posedge clk); #1;
      rd(8'h80, d); check("R4 rising latch word 0", d, 32'h20);
      set_src(5, 1'b0);
      @(posedge clk); #1;
      rd(8'h80, d); check("R4 latch holds", d, 32'h20);
      rd(8'h84, d); check("R4 no falling yet", d, 32'h0);
      set_src(33, 1'b0);
      @(posedge clk); #1;
      rd(8'h84, d); check("R4 falling latch word 1", d, 32'h2);
      check("R4 irq line", {31'b0, irq_o}, 32'h1);
      wr(8'h80, 32'h0, 4'hF);
      rd(8'h80, d); check("R5 write zero keeps latch", d, 32'h20);
      wr(8'h80, 32'h20, 4'hF);
      rd(8'h80, d); check("R5 W1C clears", d, 32'h0);
      rd(8'h20, d); check("R5 vector after ack", d, 32'h21);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      do_reset();
      wr_ctrl(7, 8'h00);
      set_src(7, 1'b1);
      rd(8'h80, d); check("R6 status while disabled", d, 32'h80);
      rd(8'h20, d); check("R6 vector idle", d, 32'h3F);
      check("R6 irq low", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_route();
      logic [31:0] d;
      do_reset();
      wr_ctrl(12, 8'h0C);
      wr_ctrl(20, 8'h09);
      wr_ctrl(21, 8'h0F);
      set_src(12, 1'b1);
      set_src(20, 1'b1);
      set_src(21, 1'b1);
      @(negedge clk);
      check("R7 aux lines", {26'b0, aux_o}, 32'h24);
      check("R7 fiq line", {31'b0, fiq_o}, 32'h1);
      check("R7 irq line idle", {31'b0, irq_o}, 32'h0);
      rd(8'h24, d); check("R8 fiq vector", d, 32'd20);
   endtask

   task automatic t_fixed();
      logic [31:0] d;
      do_reset();
      wr_ctrl(40, 8'h08);
      wr_ctrl(10, 8'h08);
      set_src(40, 1'b1);
      rd(8'h20, d); check("R8 single source", d, 32'd40);
      set_src(10, 1'b1);
      rd(8'h20, d); check("R8 lowest wins", d, 32'd10);
   endtask

   task automatic t_src63();
      logic [31:0] d;
      do_reset();
      rd(8'h84, d); check("R9 idle status bit 31", d, 32'h0);
      wr_ctrl(63, 8'h08);
      set_src(63, 1'b1);
      rd(8'h20, d); check("R9 real 63 vector", d, 32'h3F);
      rd(8'h84, d); check("R9 real 63 status", d, 32'h80000000);
   endtask

   task automatic t_rotate();
      logic [31:0] d;
      do_reset();
      wr_ctrl(3, 8'h08);
      wr_ctrl(10, 8'h08);
      wr_ctrl(40, 8'h08);
      set_src(3, 1'b1); set_src(10, 1'b1); set_src(40, 1'b1);
      wr(8'h20, 32'h40, 4'h1);
      rd(8'h20, d); check("R11 rotate bit readback", d, 32'h43);
      wr(8'h80, 32'h400, 4'hF);
      rd(8'h20, d); check("R10 non-winner write ignored", d, 32'h43);
      wr(8'h80, 32'h8, 4'hF);
      rd(8'h20, d); check("R10 after ack 3", d, 32'h4A);
      wr(8'h80, 32'h400, 4'hF);
      rd(8'h20, d); check("R10 after ack 10", d, 32'h68);
      wr(8'h84, 32'h100, 4'hF);
      rd(8'h20, d); check("R10 wrap after ack 40", d, 32'h43);
      wr(8'h80, 32'h8, 4'hF);
      rd(8'h20, d); check("R10 pointer at 3", d, 32'h4A);
      wr(8'h20, 32'h0, 4'h1);
      rd(8'h20, d); check("R11 fixed again", d, 32'h03);
   endtask

   initial begin
      t_reset();
      t_ctrl_rw();
      t_level();
      t_edge();
      t_mask();
      t_route();
      t_fixed();
      t_src63();
      t_rotate();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule